// File: doc/BRIEF.md
# SONET Transmit Framing-Byte Inserter and Scrambler

This block sits on the transmit side of an STS-48 link and handles 32-bit words. Each word carries four bytes, and the first byte on the line occupies bits [31:24]. A start-of-frame strobe arrives with the first word of each frame. The block uses that strobe to count word positions over a 9720-word frame. It can write the framing pattern over the first two overhead groups of row one, and it can apply the frame-synchronous line scrambler to every byte after the 144 row-one overhead bytes.

The two functions have separate enables and can be used in any combination. The output word and a copy of the strobe leave through one register stage, ready for a 32-to-8 width converter and serializer. The position counter runs freely from one frame to the next. A strobe that arrives anywhere else restarts the count at that word.

Top module: `sts_tx_ohscr`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `tx_data_o` is 0 and `tx_fp_o` is 0.
- R2: `tx_fp_o` equals `tx_fp_i` delayed by exactly one clock. `tx_data_o` holds the result for the word that was presented one clock earlier.
- R3: Until the first `tx_fp_i` after reset, every word passes through unchanged, whatever the enables are set to.
- R4: The word that arrives with `tx_fp_i` is position 0. With `oh_ins_en_i` = 1, positions 0..11 leave as 0xF6F6F6F6 and positions 12..23 leave as 0x28282828.
- R5: With `oh_ins_en_i` = 0, positions 0..23 pass through unchanged, whatever `scr_en_i` is set to.
- R6: Positions 24..35 always pass through unchanged.
- R7: With `scr_en_i` = 1, every word at positions 36..9719 is XORed with the sequence of 1 + x^6 + x^7. The sequence is b[n] = b[n-6] XOR b[n-7], with b[0..6] = 1 at the first bit of position 36. Bit n of the sequence lands on bit 31 - (n mod 32) of the word at position 36 + n/32.
- R8: With `scr_en_i` = 0, positions 36..9719 pass through unchanged.
- R9: After position 9719 the count returns to 0 without a new strobe, so insertion and scrambling continue in the next frame.
- R10: A `tx_fp_i` at any other position makes that word position 0. Insertion and the scrambler preset follow from that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_data_i | input | 32 | Input word, first line byte in [31:24] |
| tx_fp_i | input | 1 | Start-of-frame strobe with word 0 |
| oh_ins_en_i | input | 1 | Enables the framing-byte overwrite |
| scr_en_i | input | 1 | Enables the line scrambler |
| tx_data_o | output | 32 | Processed word, one clock later |
| tx_fp_o | output | 1 | Strobe aligned with `tx_data_o` |

## Verification
Every result is due exactly one clock after its input. The word and the strobe go through one output register, and position and keystream are worked out combinationally from the current word. The bench drives each word on a falling edge, waits for the next rising edge, and compares 1 ns later. It compares both the data and the strobe for every word against a model of the frame position and a 127-entry table of the scrambler sequence built from its recurrence. Whole frames are run under each enable pair, plus a frame with no strobe and a strobe in mid-frame, so that each word lands on its expected cycle and region.

// File: rtl/sts_tx_pkg.sv
package sts_tx_pkg;

  localparam logic [7:0] A1_BYTE  = 8'hF6;
  localparam logic [7:0] A2_BYTE  = 8'h28;
  localparam logic [6:0] SCR_SEED = 7'h7F;

  // one serial step of the 1 + x^6 + x^7 generator; output bit is s[6]
  function automatic logic [6:0] scr_step(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  // 32 keystream bits starting from state s, first bit on [31]
  function automatic logic [31:0] scr_keyword(input logic [6:0] s);
    logic [6:0]  st;
    logic [31:0] k;
    st = s;
    k  = '0;
    for (int i = 0; i < 32; i++) begin
      k[31-i] = st[6];
      st      = scr_step(st);
    end
    return k;
  endfunction

  // state after 32 serial steps
  function automatic logic [6:0] scr_advance32(input logic [6:0] s);
    logic [6:0] st;
    st = s;
    for (int i = 0; i < 32; i++) st = scr_step(st);
    return st;
  endfunction

endpackage

// File: rtl/sts_frame_tracker.sv
module sts_frame_tracker #(
  parameter int FRAME_WORDS = 9720,
  parameter int A1_WORDS    = 12,
  parameter int TOH_WORDS   = 36,
  localparam int POS_W      = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fp_i,
  output logic             locked_o,
  output logic [POS_W-1:0] pos_o,
  output logic             a1_o,
  output logic             a2_o,
  output logic             toh_o,
  output logic             scr_start_o,
  output logic             body_o
);

  localparam logic [POS_W-1:0] LAST    = POS_W'(FRAME_WORDS - 1);
  localparam logic [POS_W-1:0] A1_END  = POS_W'(A1_WORDS);
  localparam logic [POS_W-1:0] A2_END  = POS_W'(2 * A1_WORDS);
  localparam logic [POS_W-1:0] TOH_END = POS_W'(TOH_WORDS);

  logic             locked_q;
  logic [POS_W-1:0] pos_q;

  // a strobe always forces position 0 on its own word
  always_comb begin
    locked_o    = fp_i | locked_q;
    pos_o       = fp_i ? '0 : pos_q;
    a1_o        = locked_o && (pos_o < A1_END);
    a2_o        = locked_o && (pos_o >= A1_END) && (pos_o < A2_END);
    toh_o       = locked_o && (pos_o >= A2_END) && (pos_o < TOH_END);
    scr_start_o = locked_o && (pos_o == TOH_END);
    body_o      = locked_o && (pos_o >= TOH_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      pos_q    <= '0;
    end else if (locked_o) begin
      locked_q <= 1'b1;
      pos_q    <= (pos_o == LAST) ? '0 : pos_o + 1'b1;
    end
  end

  // R10: the word after a strobe is position 1
  p_resync_next_r10: assert property (@(posedge clk) disable iff (rst)
    fp_i |=> (pos_q == POS_W'(1)));

  // R3: once locked, lock is never lost
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);

  // R9: position stays within the frame
  p_pos_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);

endmodule

// File: rtl/sts_scr_gen.sv
module sts_scr_gen
  import sts_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        restart_i,
  output logic [31:0] key_o
);

  logic [6:0] state_q;
  logic [6:0] seed;

  always_comb begin
    seed  = restart_i ? SCR_SEED : state_q;
    key_o = scr_keyword(seed);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SCR_SEED;
    else     state_q <= scr_advance32(seed);
  end

  // R7: the generator never falls into the all-zero state
  p_state_live_r7: assert property (@(posedge clk) disable iff (rst)
    state_q != 7'd0);

endmodule

// File: rtl/sts_oh_mux.sv
module sts_oh_mux
  import sts_tx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] word_i,
  input  logic               a1_i,
  input  logic               a2_i,
  input  logic               body_i,
  input  logic               ins_en_i,
  input  logic               scr_en_i,
  input  logic [8*LANES-1:0] key_i,
  output logic [8*LANES-1:0] word_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] in_b;
    logic [7:0] key_b;
    logic [7:0] out_b;
    assign in_b  = word_i[8*g +: 8];
    assign key_b = key_i[8*g +: 8];
    always_comb begin
      if (ins_en_i && a1_i)        out_b = A1_BYTE;
      else if (ins_en_i && a2_i)   out_b = A2_BYTE;
      else if (scr_en_i && body_i) out_b = in_b ^ key_b;
      else                         out_b = in_b;
    end
    assign word_o[8*g +: 8] = out_b;
  end

endmodule

// File: rtl/sts_tx_ohscr.sv
module sts_tx_ohscr
  import sts_tx_pkg::*;
#(
  parameter int STS_N = 48
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] tx_data_i,
  input  logic        tx_fp_i,
  input  logic        oh_ins_en_i,
  input  logic        scr_en_i,
  output logic [31:0] tx_data_o,
  output logic        tx_fp_o
);

  localparam int LANES       = 4;
  localparam int ROW_BYTES   = 90 * STS_N;
  localparam int FRAME_WORDS = 9 * ROW_BYTES / LANES;
  localparam int A1_WORDS    = STS_N / LANES;
  localparam int TOH_WORDS   = 3 * STS_N / LANES;
  localparam int POS_W       = $clog2(FRAME_WORDS);

  logic             trk_locked;
  logic [POS_W-1:0] trk_pos;
  logic             trk_a1, trk_a2, trk_toh, trk_scr_start, trk_body;
  logic [31:0]      key_word;
  logic [31:0]      mux_word;

  sts_frame_tracker #(
    .FRAME_WORDS(FRAME_WORDS),
    .A1_WORDS   (A1_WORDS),
    .TOH_WORDS  (TOH_WORDS)
  ) u_trk (
    .clk        (clk),
    .rst        (rst),
    .fp_i       (tx_fp_i),
    .locked_o   (trk_locked),
    .pos_o      (trk_pos),
    .a1_o       (trk_a1),
    .a2_o       (trk_a2),
    .toh_o      (trk_toh),
    .scr_start_o(trk_scr_start),
    .body_o     (trk_body)
  );

  sts_scr_gen u_scr (
    .clk      (clk),
    .rst      (rst),
    .restart_i(trk_scr_start),
    .key_o    (key_word)
  );

  sts_oh_mux #(.LANES(LANES)) u_mux (
    .word_i  (tx_data_i),
    .a1_i    (trk_a1),
    .a2_i    (trk_a2),
    .body_i  (trk_body),
    .ins_en_i(oh_ins_en_i),
    .scr_en_i(scr_en_i),
    .key_i   (key_word),
    .word_o  (mux_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data_o <= '0;
      tx_fp_o   <= 1'b0;
    end else begin
      tx_data_o <= mux_word;
      tx_fp_o   <= tx_fp_i;
    end
  end

  // R2: strobe latency matches data latency
  p_fp_follow_r2: assert property (@(posedge clk) disable iff (rst)
    tx_fp_i |=> tx_fp_o);
  p_fp_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !tx_fp_i |=> !tx_fp_o);

  // R3: nothing is altered before framing is known
  p_pass_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
    !trk_locked |=> (tx_data_o == $past(tx_data_i)));

  // R4: framing bytes forced
  p_a1_force_r4: assert property (@(posedge clk) disable iff (rst)
    (oh_ins_en_i && trk_a1) |=> (tx_data_o == {LANES{A1_BYTE}}));
  p_a2_force_r4: assert property (@(posedge clk) disable iff (rst)
    (oh_ins_en_i && trk_a2) |=> (tx_data_o == {LANES{A2_BYTE}}));

  // R6: remaining row-one overhead untouched
  p_toh_pass_r6: assert property (@(posedge clk) disable iff (rst)
    trk_toh |=> (tx_data_o == $past(tx_data_i)));

  // R8: scrambler off leaves the payload region untouched
  p_scr_off_r8: assert property (@(posedge clk) disable iff (rst)
    (trk_body && !scr_en_i) |=> (tx_data_o == $past(tx_data_i)));

endmodule

// File: tb/sts_tx_ohscr_bench.sv
`timescale 1ns/1ps
module sts_tx_ohscr_bench;

  localparam int FW   = 9720;
  localparam int A1E  = 12;
  localparam int A2E  = 24;
  localparam int TOHE = 36;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic        fp  = 1'b0;
  logic        ins = 1'b0;
  logic        scr = 1'b0;
  logic [31:0] dout;
  logic        fp_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  bit seq [127];
  int m_pos    = 0;
  bit m_locked = 1'b0;
  int word_no  = 0;

  always #2 clk = ~clk;

  sts_tx_ohscr u_sts_tx_ohscr (
    .clk        (clk),
    .rst        (rst),
    .tx_data_i  (din),
    .tx_fp_i    (fp),
    .oh_ins_en_i(ins),
    .scr_en_i   (scr),
    .tx_data_o  (dout),
    .tx_fp_o    (fp_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: word %0d pos %0d act %h exp %h", tag, word_no, m_pos, act, exp);
    end
  endtask

  function automatic logic [31:0] ks(input int pos);
    logic [31:0] k;
    int off;
    off = (pos - TOHE) * 32;
    for (int i = 0; i < 32; i++) k[31-i] = seq[(off + i) % 127];
    return k;
  endfunction

  task automatic drive_word(input logic f, input logic ie, input logic se, input string tag_over);
    logic [31:0] exp;
    string tag;
    @(negedge clk);
    din = (word_no * 32'h9E3779B9) ^ 32'h5A5A0F0F;
    fp  = f;
    ins = ie;
    scr = se;
    if (f) begin
      m_pos    = 0;
      m_locked = 1'b1;
    end
    if (!m_locked) begin
      exp = din; tag = "R3";
    end else if (m_pos < A1E) begin
      exp = ie ? 32'hF6F6F6F6 : din; tag = ie ? "R4" : "R5";
    end else if (m_pos < A2E) begin
      exp = ie ? 32'h28282828 : din; tag = ie ? "R4" : "R5";
    end else if (m_pos < TOHE) begin
      exp = din; tag = "R6";
    end else begin
      exp = se ? (din ^ ks(m_pos)) : din; tag = se ? "R7" : "R8";
    end
    if (tag_over != "") tag = tag_over;
    @(posedge clk);
    #1;
    check(tag, dout, exp);
    check("R2", {31'd0, fp_out}, {31'd0, f});
    if (m_locked) m_pos = (m_pos == FW - 1) ? 0 : m_pos + 1;
    word_no++;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    din = 32'hFFFF_FFFF;
    fp  = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", dout, 32'h0);
    check("R1", {31'd0, fp_out}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    fp  = 1'b0;
  endtask

  task automatic t_unlocked();
    for (int i = 0; i < 20; i++) drive_word(1'b0, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_frame(input logic with_fp, input logic ie, input logic se, input string first_tag);
    for (int i = 0; i < FW; i++)
      drive_word(with_fp && (i == 0), ie, se, (i == 0) ? first_tag : "");
  endtask

  task automatic t_flywheel();
    // no strobe: count must wrap by itself
    for (int i = 0; i < FW; i++)
      drive_word(1'b0, 1'b1, 1'b1, (i < TOHE + 2) ? "R9" : "");
  endtask

  task automatic t_resync();
    for (int i = 0; i < 5000; i++) drive_word(1'b0, 1'b1, 1'b1, "");
    for (int i = 0; i < TOHE + 4; i++) drive_word(i == 0, 1'b1, 1'b1, "R10");
    for (int i = TOHE + 4; i < FW; i++) drive_word(1'b0, 1'b1, 1'b1, "");
  endtask

  initial begin
    for (int n = 0; n < 127; n++) seq[n] = (n < 7) ? 1'b1 : (seq[n-6] ^ seq[n-7]);
    t_reset();
    t_unlocked();
    t_frame(1'b1, 1'b1, 1'b1, "R4");
    t_flywheel();
    t_frame(1'b1, 1'b0, 1'b0, "R5");
    t_frame(1'b1, 1'b1, 1'b0, "R8");
    t_frame(1'b1, 1'b0, 1'b1, "R7");
    t_resync();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule